// File: doc/BRIEF.md
# Mask register merge unit

This block builds one destination mask register from a short stream of partial mask registers. Each partial register comes from one micro-operation that handled one register of a grouped vector operation, and holds valid mask bits only in that register's own slice. A merge begins with a start pulse. The pulse carries the element size, given as a log2 byte code, and the number of partial registers to expect. The sources then arrive one per accepted cycle in ascending order. When the last source has been folded in, the unit raises a one-cycle done pulse. The merged register is held on the output until the next merge begins.

Each source register carries `(VLEN/8) >> esz_log2` mask bits. Source `i` owns the bit field that starts at bit `i * count` and is `count` bits wide. Its bits are taken from the same positions in source `i`. If `count` is 8 or more, each slice covers whole bytes. If it is smaller, several slices are packed into one byte. The destination is filled with ones when a merge starts, so every bit that no slice covers reads as one.

Top module: `mask_merge`

## Requirements
- R1: After reset `busy` and `done` are 0 and `merged` is all ones.
- R2: A `start` pulse while idle with a nonzero `src_cnt` sets `merged` to all ones and raises `busy` on the next cycle.
- R3: The per-source bit count is `(VLEN/8) >> esz_log2`, where `esz_log2` codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 byte elements. Source `i` (0-based, in arrival order) writes bits `[i*count +: count]` of `merged` with the same bits of `src_data`.
- R4: When the count is below 8, several sources share one byte of `merged` and each changes only its own bits.
- R5: When the count is 8 or more, each source fills whole bytes of `merged` at byte offset `i*count/8`.
- R6: Bits of `merged` covered by no source slice read as one after the merge.
- R7: `done` is high for exactly one cycle, in the cycle after the last source is accepted, and `busy` is low in that cycle.
- R8: Cycles in which `busy` is high and `src_valid` is low leave `merged` unchanged and do not advance the source index.
- R9: A `start` pulse while `busy` is high is ignored; the running merge completes with its original size and count.
- R10: `src_valid` while idle has no effect on `merged`.
- R11: A `start` with `src_cnt` of 0 produces `done` in the next cycle with `merged` all ones, and `busy` stays low.
- R12: After `done`, `merged` holds its value until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a merge (accepted only while idle) |
| esz_log2 | input | 2 | log2 of element size in bytes, sampled with start |
| src_cnt | input | $clog2(MAX_SRC+1) | Number of source registers, sampled with start |
| src_valid | input | 1 | Source register present on src_data |
| src_data | input | VLEN | Partial mask register |
| busy | output | 1 | Merge in progress, sources being accepted |
| done | output | 1 | One-cycle pulse: merged result is complete |
| merged | output | VLEN | Merged mask register |

## Verification
On every cycle, the assertions check three things. An accepted source changes `merged` only inside its own slice. An idle or stalled cycle leaves `merged` unchanged. A start while busy leaves the captured size and count untouched. They also check that `done` never coincides with `busy`, and that an idle start clears the result to all ones. Some properties need knowledge of the whole stream: that the packed bit positions are correct for every element size, that the tail bits end up as ones, and that `done` appears in exactly the right cycle, including with gaps in the stream and with a zero count. Only the bench scenarios can show these, by comparing each result against a model built from the source values.

// File: rtl/mask_merge.sv
module mask_merge #(
  parameter int VLEN    = 128,
  parameter int MAX_SRC = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic [1:0]                   esz_log2,
  input  logic [$clog2(MAX_SRC+1)-1:0] src_cnt,
  input  logic                         src_valid,
  input  logic [VLEN-1:0]              src_data,
  output logic                         busy,
  output logic                         done,
  output logic [VLEN-1:0]              merged
);
  localparam int VLENB = VLEN / 8;
  localparam int CW    = $clog2(MAX_SRC + 1);

  logic [1:0]      esz_q;
  logic [CW-1:0]   cnt_q;
  logic [CW-1:0]   idx_q;
  logic [VLEN-1:0] acc_q;
  logic            busy_q;
  logic            done_q;

  logic [15:0]     per_reg;
  logic [15:0]     slice_lo;
  logic [VLEN-1:0] fmask;

  assign per_reg  = 16'(VLENB) >> esz_q;
  assign slice_lo = 16'(idx_q) * per_reg;
  assign fmask    = (~({VLEN{1'b1}} << per_reg)) << slice_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      acc_q  <= '1;
      esz_q  <= '0;
      cnt_q  <= '0;
      idx_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          acc_q <= '1;
          esz_q <= esz_log2;
          cnt_q <= src_cnt;
          idx_q <= '0;
          if (src_cnt == '0) done_q <= 1'b1;
          else               busy_q <= 1'b1;
        end
      end else if (src_valid) begin
        acc_q <= (acc_q & ~fmask) | (src_data & fmask);
        idx_q <= idx_q + 1'b1;
        if (idx_q == cnt_q - 1'b1) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy   = busy_q;
  assign done   = done_q;
  assign merged = acc_q;

  // R2
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && src_cnt != '0) |=> (busy && merged == {VLEN{1'b1}}));

  // R3
  slice_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && src_valid) |=> (((merged ^ $past(merged)) & ~$past(fmask)) == '0));

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !src_valid) |=> ($stable(merged) && $stable(idx_q)));

  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(esz_q) && $stable(cnt_q)));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(merged));
endmodule

// File: tb/tb_mask_merge.sv
module tb_mask_merge;
  localparam int VLEN    = 128;
  localparam int MAX_SRC = 8;
  localparam int CW      = $clog2(MAX_SRC + 1);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic [1:0]      esz_log2 = '0;
  logic [CW-1:0]   src_cnt = '0;
  logic            src_valid = 1'b0;
  logic [VLEN-1:0] src_data = '0;
  logic            busy, done;
  logic [VLEN-1:0] merged;

  mask_merge #(.VLEN(VLEN), .MAX_SRC(MAX_SRC)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .esz_log2(esz_log2),
    .src_cnt(src_cnt), .src_valid(src_valid), .src_data(src_data),
    .busy(busy), .done(done), .merged(merged));

  always #10 clk = ~clk;

  int tests = 0, fails = 0, cyc = 0;
  logic [VLEN-1:0] srcs [MAX_SRC];
  logic [VLEN-1:0] exp_q [$];
  int              when_q [$];
  string           tag_q [$];
  logic [31:0]     seed = 32'h1234_5678;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input logic [VLEN-1:0] act,
                       input logic [VLEN-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R7 unexpected done", VLEN'(1), VLEN'(0));
      end else begin
        logic [VLEN-1:0] e;
        int w;
        string t;
        e = exp_q.pop_front();
        w = when_q.pop_front();
        t = tag_q.pop_front();
        check(merged === e, t, merged, e);
        check(cyc == w, "R7 done cycle", VLEN'(cyc), VLEN'(w));
      end
    end
  end

  function automatic logic [31:0] rnd32();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  task automatic fill_srcs();
    for (int i = 0; i < MAX_SRC; i++)
      for (int w = 0; w < VLEN / 32; w++)
        srcs[i][w*32 +: 32] = rnd32();
  endtask

  function automatic logic [VLEN-1:0] model(input int esz, input int n);
    logic [VLEN-1:0] r;
    int per;
    r = '1;
    per = (VLEN / 8) >> esz;
    for (int i = 0; i < n; i++)
      for (int b = 0; b < per; b++)
        if (i * per + b < VLEN) r[i*per + b] = srcs[i][i*per + b];
    return r;
  endfunction

  task automatic run_merge(input int esz, input int n, input bit gaps, input string tag);
    logic [VLEN-1:0] e, hold;
    e = model(esz, n);
    @(negedge clk);
    start = 1'b1; esz_log2 = 2'(esz); src_cnt = CW'(n);
    if (n == 0) begin
      exp_q.push_back(e); when_q.push_back(cyc + 1); tag_q.push_back({tag, " R11"});
    end
    @(negedge clk);
    start = 1'b0;
    if (n != 0) begin
      check(busy === 1'b1, "R2 busy", VLEN'(busy), VLEN'(1));
      check(merged === '1, "R2 cleared", merged, '1);
      for (int i = 0; i < n; i++) begin
        if (gaps && i > 0) begin
          hold = merged;
          src_valid = 1'b0; src_data = ~srcs[i];
          start = 1'b1; esz_log2 = 2'(3 - esz); src_cnt = CW'(1);
          @(negedge clk);
          start = 1'b0;
          check(merged === hold, "R8 stall hold", merged, hold);
          check(busy === 1'b1, "R9 busy kept", VLEN'(busy), VLEN'(1));
        end
        src_valid = 1'b1; src_data = srcs[i];
        if (i == n - 1) begin
          exp_q.push_back(e); when_q.push_back(cyc + 1); tag_q.push_back(tag);
        end
        @(negedge clk);
      end
      src_valid = 1'b0;
      check(busy === 1'b0, "R7 busy low", VLEN'(busy), VLEN'(0));
    end else begin
      check(busy === 1'b0, "R11 no busy", VLEN'(busy), VLEN'(0));
    end
    @(negedge clk);
    check(done === 1'b0, "R7 one cycle", VLEN'(done), VLEN'(0));
    check(merged === e, "R12 hold", merged, e);
    src_valid = 1'b1; src_data = ~e;
    @(negedge clk);
    src_valid = 1'b0;
    check(merged === e, "R10 idle src", merged, e);
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check(busy === 1'b0, "R1 busy", VLEN'(busy), VLEN'(0));
    check(done === 1'b0, "R1 done", VLEN'(done), VLEN'(0));
    check(merged === '1, "R1 merged", merged, '1);
    rst_n = 1'b1;
    fill_srcs(); run_merge(0, 8, 1'b0, "R5 R3 byte slices");
    fill_srcs(); run_merge(1, 4, 1'b0, "R5 halfword");
    fill_srcs(); run_merge(2, 8, 1'b0, "R4 nibble pack");
    fill_srcs(); run_merge(3, 8, 1'b0, "R4 two-bit pack");
    fill_srcs(); run_merge(3, 3, 1'b0, "R6 tail ones");
    fill_srcs(); run_merge(0, 1, 1'b0, "R6 single source");
    run_merge(1, 0, 1'b0, "R11 empty");
    fill_srcs(); run_merge(2, 5, 1'b1, "R8 R9 gaps");
    fill_srcs(); run_merge(1, 8, 1'b1, "R9 poke full");
    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, "R7 all done seen", VLEN'(exp_q.size()), VLEN'(0));
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule